// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block sits on the host side of a parallel ATA channel and turns one command request into the exact series of register accesses a device needs before it starts work. A request carries the target unit (0 or 1), a 16-bit feature value, a 16-bit sector count, a 48-bit LBA, the command opcode and a flag that selects 48-bit addressing. The block drives a plain register bus with a 4-bit address, a write strobe, a read strobe and 8-bit data. It first selects the device. It then reads the status register once per cycle until the busy bit clears, and gives up after `POLL_LIMIT` busy reads. Next it turns on device interrupts. It loads the task file in the order the chosen addressing mode requires and writes the opcode last.

The result comes back as a one-cycle `done` pulse or a one-cycle `timeout_err` pulse. `busy` stays high from the edge that accepts a request until that pulse. Requests that arrive while `busy` is high are dropped. Data movement, DMA and packet commands belong to other blocks.

The controller has nine states, and its transitions are the following:
- IDLE goes to SELECT when a request is accepted.
- SELECT always goes to POLL.
- POLL goes to DEVCTL when the device is ready, goes to FAIL when the poll window runs out, and otherwise stays in POLL.
- DEVCTL always goes to LOAD.
- LOAD steps through the task-file bytes and goes to DRIVE after the last one.
- DRIVE always goes to ISSUE, and ISSUE always goes to DONE.
- DONE and FAIL both return to IDLE.

Top module: `ata_cmd_issuer`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `timeout_err`, `bus_wr` and `bus_rd` are all low.
- R2: The first access after acceptance is a write to address 6 (device select) with value 0xE0 OR (unit << 4). Bit 6 is the LBA flag, bits 7 and 5 are the legacy ones and bit 4 is the unit.
- R3: The block then reads address 7 (status) once per cycle. The device counts as busy while any bit of `BUSY_MASK` (default bit 7) is set. If `POLL_LIMIT` reads in a row all show busy, `timeout_err` pulses for one cycle, the block makes no further writes, and the number of status reads is exactly `POLL_LIMIT`.
- R4: When a status read shows ready, the next access is a write of 0x08 to address 14 (device control on the control block: interrupts enabled, bit 3 set).
- R5: In 48-bit mode the task file gets ten writes, two to each of addresses 1 to 5 in ascending order, with the high byte first: feature[15:8] then [7:0], count[15:8] then [7:0], LBA[31:24] then [7:0], LBA[39:32] then [15:8], LBA[47:40] then [23:16].
- R6: In 48-bit mode the following write to address 6 carries 0x40 OR (unit << 4) and no LBA bits.
- R7: In 28-bit mode the task file gets one write to each of addresses 1 to 5: feature[7:0], count[7:0], LBA[7:0], LBA[15:8], LBA[23:16]. The write to address 6 that follows carries 0xE0 OR (unit << 4) OR LBA[27:24].
- R8: The last write of every successful sequence is the opcode to address 7. `done` pulses in the next cycle and stays low after that.
- R9: `busy` is high from the cycle after acceptance through the `done` or `timeout_err` cycle and is low after it. A request offered while `busy` is high is ignored: the writes in flight keep the values of the first request.
- R10: The block never asserts both strobes in one cycle, and it asserts neither strobe while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered; taken only when idle |
| req_unit | input | 1 | Target unit (0 or 1) |
| req_lba48 | input | 1 | 1 selects 48-bit addressing |
| req_feature | input | 16 | Feature value |
| req_count | input | 16 | Sector count |
| req_lba | input | 48 | Logical block address |
| req_cmd | input | 8 | Command opcode |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle pulse: command issued |
| timeout_err | output | 1 | One-cycle pulse: device never became ready |
| bus_addr | output | 4 | Register address (14 = device control) |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe; `bus_rdata` is sampled in the same cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data from the device |

## Verification
The hardest cases to reach are at the edge of the poll window. In one, the device shows ready on exactly the last permitted read. In the other, it stays busy for exactly `POLL_LIMIT` reads. These two differ by one read, but one issues the command and the other aborts. The bench models the device with a status responder that reports busy for a chosen number of reads. It sweeps that number over 0, 1, 3, `POLL_LIMIT-1`, `POLL_LIMIT` and beyond, for both units and both addressing modes. In every run it also offers a second request while the first is in flight, to show that the second is dropped.

// File: rtl/ata_iss_pkg.sv
package ata_iss_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SELECT,
        S_POLL,
        S_DEVCTL,
        S_LOAD,
        S_DRIVE,
        S_ISSUE,
        S_DONE,
        S_FAIL
    } iss_state_e;

    // register addresses on the device bus
    localparam logic [3:0] A_FEAT   = 4'd1;
    localparam logic [3:0] A_DRIVE  = 4'd6;
    localparam logic [3:0] A_CMD    = 4'd7;
    localparam logic [3:0] A_DEVCTL = 4'd14;

    // drive register bits and device control value
    localparam logic [7:0] DRV_LEGACY = 8'hA0;
    localparam logic [7:0] DRV_LBA    = 8'h40;
    localparam logic [7:0] CTL_IRQ_ON = 8'h08;

    // step counts for the task-file load
    localparam int STEPS_48 = 10;
    localparam int STEPS_28 = 5;

    typedef struct packed {
        logic        unit;
        logic        lba48;
        logic [15:0] feature;
        logic [15:0] count;
        logic [47:0] lba;
        logic [7:0]  cmd;
    } iss_req_t;

endpackage

// File: rtl/ata_tf_step.sv
module ata_tf_step
    import ata_iss_pkg::*;
(
    input  iss_req_t   req,
    input  logic [3:0] idx,
    output logic [3:0] addr,
    output logic [7:0] data,
    output logic       last
);

    logic [2:0] slot;
    logic       hi;

    always_comb begin
        if (req.lba48) begin
            slot = idx[3:1];
            hi   = ~idx[0];
            last = (idx == 4'(STEPS_48 - 1));
        end else begin
            slot = idx[2:0];
            hi   = 1'b0;
            last = (idx == 4'(STEPS_28 - 1));
        end
        addr = A_FEAT + {1'b0, slot};
        case (slot)
            3'd0:    data = hi ? req.feature[15:8] : req.feature[7:0];
            3'd1:    data = hi ? req.count[15:8]   : req.count[7:0];
            3'd2:    data = hi ? req.lba[31:24]    : req.lba[7:0];
            3'd3:    data = hi ? req.lba[39:32]    : req.lba[15:8];
            default: data = hi ? req.lba[47:40]    : req.lba[23:16];
        endcase
    end

endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ata_iss_fsm.sv
module ata_iss_fsm
    import ata_iss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       expired,
    input  logic       step_last,
    output iss_state_e state,
    output logic [3:0] step
);

    iss_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_SELECT;
            S_SELECT: nxt = S_POLL;
            S_POLL: begin
                if (ready)        nxt = S_DEVCTL;
                else if (expired) nxt = S_FAIL;
            end
            S_DEVCTL: nxt = S_LOAD;
            S_LOAD:   if (step_last) nxt = S_DRIVE;
            S_DRIVE:  nxt = S_ISSUE;
            S_ISSUE:  nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            S_FAIL:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            step  <= '0;
        end else begin
            state <= nxt;
            if (state == S_DEVCTL)    step <= '0;
            else if (state == S_LOAD) step <= step + 1'b1;
        end
    end

endmodule

// File: rtl/ata_cmd_issuer.sv
module ata_cmd_issuer
    import ata_iss_pkg::*;
#(
    parameter int         POLL_LIMIT = 16,
    parameter logic [7:0] BUSY_MASK  = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_unit,
    input  logic        req_lba48,
    input  logic [15:0] req_feature,
    input  logic [15:0] req_count,
    input  logic [47:0] req_lba,
    input  logic [7:0]  req_cmd,
    output logic        busy,
    output logic        done,
    output logic        timeout_err,
    output logic [3:0]  bus_addr,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata
);

    iss_state_e state;
    iss_req_t   req_q;
    logic [3:0] step;
    logic [3:0] step_addr;
    logic [7:0] step_data;
    logic       step_last;
    logic       expired;
    logic       ready;
    logic [7:0] sel_byte;

    assign ready    = ((bus_rdata & BUSY_MASK) == 8'h00);
    assign sel_byte = DRV_LEGACY | DRV_LBA | {3'b000, req_q.unit, 4'h0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (state == S_IDLE && req_valid) begin
            req_q <= '{unit: req_unit, lba48: req_lba48, feature: req_feature,
                       count: req_count, lba: req_lba, cmd: req_cmd};
        end
    end

    ata_iss_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .expired   (expired),
        .step_last (step_last),
        .state     (state),
        .step      (step)
    );

    ata_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_POLL),
        .expired (expired)
    );

    ata_tf_step u_step (
        .req  (req_q),
        .idx  (step),
        .addr (step_addr),
        .data (step_data),
        .last (step_last)
    );

    always_comb begin
        busy        = (state != S_IDLE);
        done        = 1'b0;
        timeout_err = 1'b0;
        bus_addr    = 4'd0;
        bus_wr      = 1'b0;
        bus_rd      = 1'b0;
        bus_wdata   = 8'h00;
        unique case (state)
            S_IDLE: ;
            S_SELECT: begin
                bus_wr    = 1'b1;
                bus_addr  = A_DRIVE;
                bus_wdata = sel_byte;
            end
            S_POLL: begin
                bus_rd   = 1'b1;
                bus_addr = A_CMD;
            end
            S_DEVCTL: begin
                bus_wr    = 1'b1;
                bus_addr  = A_DEVCTL;
                bus_wdata = CTL_IRQ_ON;
            end
            S_LOAD: begin
                bus_wr    = 1'b1;
                bus_addr  = step_addr;
                bus_wdata = step_data;
            end
            S_DRIVE: begin
                bus_wr    = 1'b1;
                bus_addr  = A_DRIVE;
                bus_wdata = req_q.lba48 ? (DRV_LBA | {3'b000, req_q.unit, 4'h0})
                                        : (sel_byte | {4'h0, req_q.lba[27:24]});
            end
            S_ISSUE: begin
                bus_wr    = 1'b1;
                bus_addr  = A_CMD;
                bus_wdata = req_q.cmd;
            end
            S_DONE: done        = 1'b1;
            S_FAIL: timeout_err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ata_cmd_issuer_chk.sv
module ata_cmd_issuer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       timeout_err,
    input logic [3:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata
);

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_wr && !bus_rd));

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    p_devctl_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd14) |-> (bus_wdata == 8'h08));

    p_cmd_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd7) |=> done);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !timeout_err) |=> busy);

    p_fail_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!bus_wr && !done));

    p_fail_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> (!timeout_err && !busy));

endmodule

bind ata_cmd_issuer ata_cmd_issuer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata)
);

// File: tb/ata_cmd_issuer_bench.sv
module ata_cmd_issuer_bench;

    localparam int LIMIT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_unit = 1'b0;
    logic        req_lba48 = 1'b0;
    logic [15:0] req_feature = '0;
    logic [15:0] req_count = '0;
    logic [47:0] req_lba = '0;
    logic [7:0]  req_cmd = '0;
    logic        busy, done, timeout_err, bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;

    int total = 0;
    int errs = 0;

    // device model: write log and status responder
    logic [3:0] la [0:1023];
    logic [7:0] ld [0:1023];
    int nw = 0;
    int nr = 0;
    int nr_base = 0;
    int busy_reads = 0;

    logic [3:0] ea [0:15];
    logic [7:0] ed [0:15];
    int ne;

    always #2 clk = ~clk;

    assign bus_rdata = ((nr - nr_base) < busy_reads) ? 8'hD0 : 8'h50;

    always @(posedge clk) begin
        if (bus_wr) begin
            if (nw < 1024) begin
                la[nw] <= bus_addr;
                ld[nw] <= bus_wdata;
            end
            nw <= nw + 1;
        end
        if (bus_rd && bus_addr == 4'd7) nr <= nr + 1;
    end

    ata_cmd_issuer #(.POLL_LIMIT(LIMIT)) u_ata_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
        .req_lba48(req_lba48), .req_feature(req_feature), .req_count(req_count),
        .req_lba(req_lba), .req_cmd(req_cmd), .busy(busy), .done(done),
        .timeout_err(timeout_err), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] a, input logic [7:0] d);
        ea[ne] = a;
        ed[ne] = d;
        ne++;
    endtask

    task automatic build(input bit u, input bit m, input bit fail,
                         input logic [15:0] f, input logic [15:0] c,
                         input logic [47:0] l, input logic [7:0] cm);
        ne = 0;
        push(4'd6, 8'hE0 | (8'(u) << 4));                       // R2
        if (!fail) begin
            push(4'd14, 8'h08);                                  // R4
            if (m) begin                                         // R5
                push(4'd1, 8'(f >> 8));  push(4'd1, 8'(f));
                push(4'd2, 8'(c >> 8));  push(4'd2, 8'(c));
                for (int s = 0; s < 3; s++) begin
                    push(4'(3 + s), 8'(l >> (24 + 8 * s)));
                    push(4'(3 + s), 8'(l >> (8 * s)));
                end
                push(4'd6, 8'h40 | (8'(u) << 4));                // R6
            end else begin                                       // R7
                push(4'd1, 8'(f));
                push(4'd2, 8'(c));
                for (int s = 0; s < 3; s++) push(4'(3 + s), 8'(l >> (8 * s)));
                push(4'd6, 8'hE0 | (8'(u) << 4) | 8'((l >> 24) & 48'hF));
            end
            push(4'd7, cm);                                      // R8
        end
    endtask

    task automatic run_case(input bit u, input bit m, input int k, input int n);
        logic [15:0] f;
        logic [15:0] c;
        logic [47:0] l;
        logic [7:0]  cm;
        int wbase, waited;
        bit fail;
        f    = 16'h1234 + 16'(n * 16'h0457);
        c    = 16'hA05B ^ 16'(n * 16'h0131);
        l    = 48'h9A_7C5E_3F21 + 48'(n) * 48'h0102_0304_0506;
        cm   = 8'h20 + 8'(n * 3);
        fail = (k >= LIMIT);
        build(u, m, fail, f, c, l, cm);

        @(negedge clk);
        busy_reads = k;
        nr_base = nr;
        wbase = nw;
        req_unit = u; req_lba48 = m; req_feature = f; req_count = c;
        req_lba = l; req_cmd = cm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 1);
        @(negedge clk);
        // distractor request while busy (R9: must be ignored)
        req_unit = ~u; req_lba48 = ~m; req_feature = ~f; req_count = ~c;
        req_lba = ~l; req_cmd = ~cm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done && !timeout_err && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 300, "R8 completion pulse seen", 64'(waited), 0);
        chk(done == !fail, "R8 done", 64'(done), 64'(!fail));
        chk(timeout_err == fail, "R3 timeout_err", 64'(timeout_err), 64'(fail));
        chk(busy == 1'b1, "R9 busy in final cycle", 64'(busy), 1);
        chk((nr - nr_base) == (fail ? LIMIT : k + 1), "R3 status read count",
            64'(nr - nr_base), 64'(fail ? LIMIT : k + 1));
        chk((nw - wbase) == ne, "R9 write count", 64'(nw - wbase), 64'(ne));
        for (int j = 0; j < ne && j < (nw - wbase); j++) begin
            chk(la[wbase + j] == ea[j], m ? "R5 write address" : "R7 write address",
                64'(la[wbase + j]), 64'(ea[j]));
            chk(ld[wbase + j] == ed[j], m ? "R6 write data" : "R7 write data",
                64'(ld[wbase + j]), 64'(ed[j]));
        end
        @(negedge clk);
        chk(!done && !timeout_err && !busy, "R9 back to idle",
            64'({busy, done, timeout_err}), 0);
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", total, errs);
        $finish;
    end

    initial begin
        int klist [6];
        int n;
        klist = '{0, 1, 3, LIMIT - 1, LIMIT, LIMIT + 3};
        repeat (3) @(negedge clk);
        chk({busy, done, timeout_err, bus_wr, bus_rd} == 5'b0, "R1 reset outputs",
            64'({busy, done, timeout_err, bus_wr, bus_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, timeout_err, bus_wr, bus_rd} == 5'b0, "R1 after reset",
            64'({busy, done, timeout_err, bus_wr, bus_rd}), 0);
        n = 0;
        for (int u = 0; u < 2; u++)
            for (int m = 0; m < 2; m++)
                for (int i = 0; i < 6; i++) begin
                    run_case(u[0], m[0], klist[i], n);
                    n++;
                end
        // R10: idle with no request leaves the bus quiet
        repeat (4) @(negedge clk);
        chk(!bus_wr && !bus_rd && !busy, "R10 idle bus quiet",
            64'({bus_wr, bus_rd, busy}), 0);
        $display("== %0d vectors applied, %0d miscompares ==", total, errs);
        $finish;
    end

endmodule